// File: doc/BRIEF.md
# Preamble-Synchronised Packet Header Parser

This block sits behind a 16-bit receive FIFO that shows its next entry at the head. The FIFO fills from a serial link. The parser pops halves from the FIFO and looks for a four-word packet header. Each 32-bit header word arrives as two 16-bit halves, with the low half first. The first two header words are fixed sync patterns. The third word gives the packet type and the fourth gives the packet size in 32-bit words.

When a header is valid, the block presents a four-word notify request to the host message path for one cycle. It also counts image-data frames. It then stops popping until the body mover reports that the packet body has been consumed. A choke flag holds the receive side shut from reset until the first outbound command has gone out. While the flag is set, every popped half is thrown away unparsed. A fatal-error input stops the parser, returns it to the hunt and closes the choke again.

Top module: `hdr_sync_parser`

## Requirements
- R1: After reset, `choke` is 1, `nfy_valid` is 0, `frame_count` is 0, `pre_err` is 0 and `fifo_pop` is 0 while the FIFO is empty.
- R2: While `choke` is 1, the block pops every available half and discards it without parsing. No notify is produced and `pre_err` is untouched. A `first_tx_done` pulse clears `choke` from the next cycle on.
- R3: The sync sequence is four single pops in this order: 0xA5A5, 0xA5A5, 0x5A5A, 0x5A5A. A half that matches only the other pattern counts as a mismatch.
- R4: A sync half that mismatches sets the sticky flag `pre_err` to 1. It also loads the half into `bad_half` and restarts the hunt at the first sync half.
- R5: The type and size words are each built as {second half, first half}. The only accepted types are reply 0x20205250 and image data 0x20204144.
- R6: A header with any other type produces no notify and leaves `frame_count` and `pre_err` unchanged. The halves that follow are discarded silently until a 0xA5A5 arrives, which is taken as the first sync half.
- R7: `nfy_valid` is a one-cycle pulse in the cycle after the last size half is popped. The words are `nfy_w0`=0x4E4659, `nfy_w1`=type[23:0], `nfy_w2`={0x00, size[31:16]} and `nfy_w3`={0x00, size[15:0]}. The words hold their values until the next notify.
- R8: `frame_count` rises by one with each image-data notify and never changes at any other time.
- R9: From a notify until a `body_done` pulse, `fifo_pop` stays 0. After `body_done` the hunt resumes.
- R10: `fatal_err` is honoured in any state. It pops nothing in that cycle, returns the parser to the hunt, sets `choke`, clears `pre_err`, and takes priority over `first_tx_done`.
- R11: `fifo_pop` is 1 only when `fifo_not_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_data | input | 16 | Head entry of the receive FIFO |
| fifo_not_empty | input | 1 | The FIFO holds at least one half |
| fifo_pop | output | 1 | Consumes the head entry at this clock edge |
| first_tx_done | input | 1 | Pulse: the first outbound command has been sent |
| fatal_err | input | 1 | Pulse from the host: abort and re-initialise |
| body_done | input | 1 | Pulse: the packet body has been moved, resume the hunt |
| choke | output | 1 | Receive side shut; popped data is dropped |
| pre_err | output | 1 | Sticky flag for a sync mismatch |
| bad_half | output | 16 | Last half that failed a sync compare |
| nfy_valid | output | 1 | One-cycle notify strobe |
| nfy_w0 | output | 24 | Notify tag word |
| nfy_w1 | output | 24 | Packet type, low 24 bits |
| nfy_w2 | output | 24 | Packet size, high half |
| nfy_w3 | output | 24 | Packet size, low half |
| frame_count | output | FCW (16) | Image-data frames seen |

## Verification
A state register that has slipped shows up as a notify in the wrong place or a missing notify. It can also show up as `bad_half` loaded with a half that should have matched. Both appear within eight pops of the fault. Halves taken in the wrong order corrupt `nfy_w1` to `nfy_w3` as soon as the next notify is presented. A stall that is not held is visible at once as `fifo_pop` high while a notify is still pending. The bench sees it as FIFO entries that vanish before `body_done`. A choke flag that clears too early, or a fatal that does not close it again, lets a header through into a notify that the scoreboard does not expect.

// File: rtl/hsp_pkg.sv
// Shared types and fixed sync patterns for the header parser.
package hsp_pkg;
    localparam logic [15:0] SYNC1_HALF = 16'hA5A5;
    localparam logic [15:0] SYNC2_HALF = 16'h5A5A;

    typedef enum logic [3:0] {
        ST_S1_LO, ST_S1_HI, ST_S2_LO, ST_S2_HI,
        ST_TY_LO, ST_TY_HI, ST_SZ_LO, ST_SZ_HI,
        ST_WAIT,  ST_SKIP
    } hsp_state_e;
endpackage

// File: rtl/hsp_choke.sv
// Choke flag. Set by reset and by a fatal error, cleared by the first outbound command.
// Assumes a fatal error outranks a simultaneous clear request.
module hsp_choke (
    input  logic clk,
    input  logic rst_n,
    input  logic fatal_err,
    input  logic first_tx_done,
    output logic choke
);
    // Hold the receive side shut until it is opened.
    always_ff @(posedge clk) begin
        if (!rst_n)             choke <= 1'b1;
        else if (fatal_err)     choke <= 1'b1;
        else if (first_tx_done) choke <= 1'b0;
    end
endmodule

// File: rtl/hsp_hdr_fsm.sv
// Header hunt state machine. It pops the FIFO, checks the sync halves,
// assembles type and size (low half first) and flags an accepted header.
// Assumes the FIFO head is valid whenever not-empty is high.
module hsp_hdr_fsm
    import hsp_pkg::*;
#(
    parameter int          DW         = 16,
    parameter logic [31:0] TYPE_REPLY = 32'h2020_5250,
    parameter logic [31:0] TYPE_DATA  = 32'h2020_4144
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   fifo_data,
    input  logic            fifo_not_empty,
    input  logic            choke,
    input  logic            fatal_err,
    input  logic            body_done,
    output logic            fifo_pop,
    output logic            accept,
    output logic            is_data,
    output logic [2*DW-1:0] ptype,
    output logic [2*DW-1:0] psize,
    output logic            pre_err,
    output logic [DW-1:0]   bad_half
);
    hsp_state_e    state;
    logic [DW-1:0] type_lo, type_hi, size_lo;
    logic          take;
    logic          type_ok;

    assign ptype    = {type_hi, type_lo};
    assign psize    = {fifo_data, size_lo};
    assign type_ok  = (ptype == TYPE_REPLY) || (ptype == TYPE_DATA);
    assign is_data  = (ptype == TYPE_DATA);
    // Pop when data is present, unless a fatal error is pending or a notify is waiting.
    assign fifo_pop = fifo_not_empty && !fatal_err && (choke || state != ST_WAIT);
    assign take     = fifo_pop && !choke;
    assign accept   = take && (state == ST_SZ_HI) && type_ok;

    // Advance the hunt on each parsed half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_S1_LO;
            pre_err  <= 1'b0;
            bad_half <= '0;
            type_lo  <= '0;
            type_hi  <= '0;
            size_lo  <= '0;
        end else if (fatal_err) begin
            state   <= ST_S1_LO;
            pre_err <= 1'b0;
        end else if (state == ST_WAIT) begin
            if (body_done) state <= ST_S1_LO;
        end else if (take) begin
            unique case (state)
                ST_S1_LO, ST_S1_HI, ST_S2_LO, ST_S2_HI: begin
                    if (fifo_data == ((state == ST_S1_LO || state == ST_S1_HI) ? SYNC1_HALF : SYNC2_HALF)) begin
                        state <= hsp_state_e'(state + 4'd1);
                    end else begin
                        pre_err  <= 1'b1;
                        bad_half <= fifo_data;
                        state    <= ST_S1_LO;
                    end
                end
                ST_TY_LO: begin type_lo <= fifo_data; state <= ST_TY_HI; end
                ST_TY_HI: begin type_hi <= fifo_data; state <= ST_SZ_LO; end
                ST_SZ_LO: begin size_lo <= fifo_data; state <= ST_SZ_HI; end
                ST_SZ_HI: state <= type_ok ? ST_WAIT : ST_SKIP;
                ST_SKIP:  if (fifo_data == SYNC1_HALF) state <= ST_S1_HI;
                default:  state <= ST_S1_LO;
            endcase
        end
    end
endmodule

// File: rtl/hsp_notify.sv
// Notify word register and frame counter. Loads the four notify words on an
// accepted header and pulses the valid strobe for one cycle.
module hsp_notify #(
    parameter int          FCW = 16,
    parameter logic [23:0] TAG = 24'h4E4659
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  logic           is_data,
    input  logic [31:0]    ptype,
    input  logic [31:0]    psize,
    output logic           nfy_valid,
    output logic [23:0]    nfy_w0,
    output logic [23:0]    nfy_w1,
    output logic [23:0]    nfy_w2,
    output logic [23:0]    nfy_w3,
    output logic [FCW-1:0] frame_count
);
    // Capture the notify request and pulse the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nfy_valid <= 1'b0;
            nfy_w0 <= '0; nfy_w1 <= '0; nfy_w2 <= '0; nfy_w3 <= '0;
        end else begin
            nfy_valid <= accept;
            if (accept) begin
                nfy_w0 <= TAG;
                nfy_w1 <= ptype[23:0];
                nfy_w2 <= {8'h00, psize[31:16]};
                nfy_w3 <= {8'h00, psize[15:0]};
            end
        end
    end

    // Count accepted image-data headers.
    always_ff @(posedge clk) begin
        if (!rst_n)                 frame_count <= '0;
        else if (accept && is_data) frame_count <= frame_count + 1'b1;
    end
endmodule

// File: rtl/hdr_sync_parser.sv
// Top level of the header parser. It wires the choke flag, the hunt state
// machine and the notify register together. It assumes a FIFO whose head is
// visible before the pop.
module hdr_sync_parser #(
    parameter int          FCW        = 16,
    parameter logic [31:0] TYPE_REPLY = 32'h2020_5250,
    parameter logic [31:0] TYPE_DATA  = 32'h2020_4144,
    parameter logic [23:0] NFY_TAG    = 24'h4E4659
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [15:0]    fifo_data,
    input  logic           fifo_not_empty,
    output logic           fifo_pop,
    input  logic           first_tx_done,
    input  logic           fatal_err,
    input  logic           body_done,
    output logic           choke,
    output logic           pre_err,
    output logic [15:0]    bad_half,
    output logic           nfy_valid,
    output logic [23:0]    nfy_w0,
    output logic [23:0]    nfy_w1,
    output logic [23:0]    nfy_w2,
    output logic [23:0]    nfy_w3,
    output logic [FCW-1:0] frame_count
);
    localparam int DW = 16;

    logic          accept, is_data;
    logic [2*DW-1:0] ptype, psize;

    hsp_choke u_choke (
        .clk(clk), .rst_n(rst_n), .fatal_err(fatal_err),
        .first_tx_done(first_tx_done), .choke(choke)
    );

    hsp_hdr_fsm #(.DW(DW), .TYPE_REPLY(TYPE_REPLY), .TYPE_DATA(TYPE_DATA)) u_fsm (
        .clk(clk), .rst_n(rst_n), .fifo_data(fifo_data),
        .fifo_not_empty(fifo_not_empty), .choke(choke), .fatal_err(fatal_err),
        .body_done(body_done), .fifo_pop(fifo_pop), .accept(accept),
        .is_data(is_data), .ptype(ptype), .psize(psize),
        .pre_err(pre_err), .bad_half(bad_half)
    );

    hsp_notify #(.FCW(FCW), .TAG(NFY_TAG)) u_nfy (
        .clk(clk), .rst_n(rst_n), .accept(accept), .is_data(is_data),
        .ptype(ptype), .psize(psize), .nfy_valid(nfy_valid),
        .nfy_w0(nfy_w0), .nfy_w1(nfy_w1), .nfy_w2(nfy_w2), .nfy_w3(nfy_w3),
        .frame_count(frame_count)
    );
endmodule

// File: rtl/hsp_checker.sv
// Port-level properties of the header parser, attached through bind.
module hsp_checker #(
    parameter int FCW = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           fifo_not_empty,
    input logic           fifo_pop,
    input logic           fatal_err,
    input logic           body_done,
    input logic           choke,
    input logic           nfy_valid,
    input logic [23:0]    nfy_w0,
    input logic [23:0]    nfy_w1,
    input logic [23:0]    nfy_w2,
    input logic [23:0]    nfy_w3,
    input logic [FCW-1:0] frame_count
);
    logic waiting;

    // Track whether a notify is waiting for its body to be moved.
    always_ff @(posedge clk) begin
        if (!rst_n)         waiting <= 1'b0;
        else if (fatal_err) waiting <= 1'b0;
        else if (body_done) waiting <= 1'b0;
        else if (nfy_valid) waiting <= 1'b1;
    end

    a_r11_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> fifo_not_empty);
    a_r10_fatal_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |-> !fifo_pop);
    a_r10_fatal_chokes: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |=> choke);
    a_r2_choke_no_notify: assert property (@(posedge clk) disable iff (!rst_n)
        choke |-> !nfy_valid);
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        nfy_valid |=> !nfy_valid);
    a_r7_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !nfy_valid |-> ($stable(nfy_w0) && $stable(nfy_w1) && $stable(nfy_w2) && $stable(nfy_w3)));
    a_r8_count_with_notify: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_count != $past(frame_count)) |-> nfy_valid);
    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting || nfy_valid) |-> !fifo_pop);
endmodule

bind hdr_sync_parser hsp_checker #(.FCW(FCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_not_empty(fifo_not_empty),
    .fifo_pop(fifo_pop), .fatal_err(fatal_err), .body_done(body_done),
    .choke(choke), .nfy_valid(nfy_valid), .nfy_w0(nfy_w0), .nfy_w1(nfy_w1),
    .nfy_w2(nfy_w2), .nfy_w3(nfy_w3), .frame_count(frame_count)
);

// File: tb/tb_hdr_sync_parser.sv
// Scoreboard bench. The driver pushes headers into a FIFO model and queues the
// expected notifies. A monitor compares each notify as it appears.
module tb_hdr_sync_parser;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] T_REPLY = 32'h2020_5250;
    localparam logic [31:0] T_DATA  = 32'h2020_4144;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fifo_data;
    logic        fifo_not_empty, fifo_pop;
    logic        first_tx_done = 1'b0, fatal_err = 1'b0, body_done = 1'b0;
    logic        choke, pre_err, nfy_valid;
    logic [15:0] bad_half, frame_count;
    logic [23:0] nfy_w0, nfy_w1, nfy_w2, nfy_w3;

    int checks = 0, errors = 0, exp_frames = 0;
    bit done = 1'b0;
    logic [111:0] expq [$];

    logic [15:0] fmem [0:255];
    logic [7:0]  wr = '0, rd = '0;
    assign fifo_not_empty = (rd != wr);
    assign fifo_data      = fmem[rd];
    always @(posedge clk) if (fifo_pop) rd <= rd + 8'd1;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdr_sync_parser dut (
        .clk(clk), .rst_n(rst_n), .fifo_data(fifo_data), .fifo_not_empty(fifo_not_empty),
        .fifo_pop(fifo_pop), .first_tx_done(first_tx_done), .fatal_err(fatal_err),
        .body_done(body_done), .choke(choke), .pre_err(pre_err), .bad_half(bad_half),
        .nfy_valid(nfy_valid), .nfy_w0(nfy_w0), .nfy_w1(nfy_w1), .nfy_w2(nfy_w2),
        .nfy_w3(nfy_w3), .frame_count(frame_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] h);
        fmem[wr] = h;
        wr = wr + 8'd1;
    endtask

    task automatic push_word(input logic [31:0] w);
        push(w[15:0]);
        push(w[31:16]);
    endtask

    // Driver: push a header, and queue its notify when one is expected.
    task automatic send_hdr(input logic [31:0] ty, input logic [31:0] sz, input bit ok);
        push_word(32'hA5A5_A5A5);
        push_word(32'h5A5A_5A5A);
        push_word(ty);
        push_word(sz);
        if (ok) begin
            if (ty == T_DATA) exp_frames++;
            expq.push_back({24'h4E4659, ty[23:0], 8'h00, sz[31:16], 8'h00, sz[15:0], 16'(exp_frames)});
        end
    endtask

    task automatic pulse(input int which);
        if (which == 0) body_done = 1'b1;
        else if (which == 1) fatal_err = 1'b1;
        else first_tx_done = 1'b1;
        @(negedge clk);
        body_done = 1'b0; fatal_err = 1'b0; first_tx_done = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each notify with the head of the scoreboard (R7, R8).
    always @(negedge clk) begin
        if (rst_n && nfy_valid) begin
            if (expq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R7 unexpected notify actual=%h%h expected=none", nfy_w1, nfy_w3);
            end else begin
                logic [111:0] e;
                e = expq.pop_front();
                chk("R7 tag", 32'(nfy_w0), 32'(e[111:88]));
                chk("R5 type word", 32'(nfy_w1), 32'(e[87:64]));
                chk("R7 size high", 32'(nfy_w2), 32'(e[63:40]));
                chk("R7 size low", 32'(nfy_w3), 32'(e[39:16]));
                chk("R8 frame count", 32'(frame_count), 32'(e[15:0]));
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        chk("R1 choke", 32'(choke), 1);
        chk("R1 nfy_valid", 32'(nfy_valid), 0);
        chk("R1 frame_count", 32'(frame_count), 0);
        chk("R1 pre_err", 32'(pre_err), 0);
        chk("R1 fifo_pop", 32'(fifo_pop), 0);

        // R2: choked traffic is drained and dropped
        send_hdr(T_DATA, 32'd5, 1'b0);
        push(16'h1234);
        idle(14);
        chk("R2 drained", 32'(wr - rd), 0);
        chk("R2 no parse", 32'(pre_err), 0);
        pulse(2);
        chk("R2 choke cleared", 32'(choke), 0);

        // R3, R5, R7, R8: valid image-data header
        send_hdr(T_DATA, 32'h0000_054B, 1'b1);
        idle(12);
        chk("R8 count after data", 32'(frame_count), 1);

        // R9: stall while the body is outstanding
        send_hdr(T_REPLY, 32'h0001_0002, 1'b1);
        idle(10);
        chk("R9 nothing popped", 32'(wr - rd), 8);
        chk("R9 pop low", 32'(fifo_pop), 0);
        pulse(0);
        idle(12);
        chk("R8 reply keeps count", 32'(frame_count), 1);
        pulse(0);

        // R4: bad first sync half, then resync
        push(16'hA5A5); push(16'h1234);
        idle(4);
        chk("R4 pre_err", 32'(pre_err), 1);
        chk("R4 bad_half", 32'(bad_half), 32'h1234);
        send_hdr(T_DATA, 32'h0000_0000, 1'b1);
        idle(12);
        chk("R4 resync count", 32'(frame_count), 2);
        pulse(0);

        // R3: word-two half mismatch, and word-two pattern in place of word one
        push(16'hA5A5); push(16'hA5A5); push(16'h5A5A); push(16'h7777);
        idle(6);
        chk("R3 second sync half", 32'(bad_half), 32'h7777);
        push(16'h5A5A);
        idle(3);
        chk("R3 order", 32'(bad_half), 32'h5A5A);

        // R10: fatal clears error, closes choke, outranks open request
        fatal_err = 1'b1; first_tx_done = 1'b1;
        idle(1);
        fatal_err = 1'b0; first_tx_done = 1'b0;
        chk("R10 choke", 32'(choke), 1);
        chk("R10 pre_err cleared", 32'(pre_err), 0);
        pulse(2);

        // R6, R5: bad type (also swapped halves) skipped silently
        send_hdr(32'hDEAD_BEEF, 32'd3, 1'b0);
        push(16'h1111); push(16'h2222);
        send_hdr(32'h4144_2020, 32'd4, 1'b0);
        push(16'h3333);
        send_hdr(T_DATA, 32'hFFFF_FFFF, 1'b1);
        idle(40);
        chk("R6 pre_err quiet", 32'(pre_err), 0);
        chk("R6 count", 32'(frame_count), 3);
        chk("R6 drained", 32'(wr - rd), 0);
        pulse(0);

        // R10: fatal while a notify is outstanding
        send_hdr(T_REPLY, 32'd7, 1'b1);
        idle(12);
        pulse(1);
        chk("R10 choke after wait", 32'(choke), 1);
        send_hdr(T_DATA, 32'd9, 1'b0);
        idle(12);
        chk("R10 dropped", 32'(wr - rd), 0);
        chk("R10 count", 32'(frame_count), 3);

        chk("R7 all notifies seen", 32'(expq.size()), 0);
        finish_run();
    end
endmodule